// File: doc/BRIEF.md
# I2C Multi-Master Bus Monitor

This block sits beside an I2C master in a bus with several masters. It watches the SCL and SDA lines through two-flop synchronizers and detects Start conditions and Stop conditions. From these it keeps a Start-seen bit and a Stop-seen bit, which tell the local controller whether another master owns the bus. A bus-free output tells the controller when it may begin a transfer of its own.

It also checks for lost arbitration. The controller gives the SDA level it intends to produce, where 1 means released, and the phase of the transfer in progress. The block compares that level with the sampled line while SCL is high, in every phase where arbitration can be lost. A mismatch latches a collision flag and releases the master's SDA driver at once. Software clears the flag. An interrupt pulse reports Start conditions, Stop conditions and new collisions, so the controller can follow bus ownership without polling.

Top module: `i2c_mm_monitor`

## Requirements
- R1: While `rst_n` is low, `start_seen`, `stop_seen`, `collision` and `irq` are 0.
- R2: While `enable` is low, `start_seen` and `stop_seen` are cleared at the next clock edge and stay clear, and no bus condition sets them.
- R3: A falling SDA while SCL is high is a Start. It sets `start_seen` and clears `stop_seen` on the third rising clock edge after the line change.
- R4: A rising SDA while SCL is high is a Stop. It sets `stop_seen` and clears `start_seen` on the third rising clock edge after the line change.
- R5: `bus_free` equals `stop_seen | (!start_seen & !stop_seen)`. The bus is therefore free after reset, while the block is disabled, and after a Stop, and busy after a Start.
- R6: When `irq_en` is high, `irq` is high for exactly one cycle, on the same edge where a detected Start or Stop updates the status bits or where `collision` rises. When `irq_en` is low, `irq` stays 0.
- R7: `collision` sets when all of the following hold for one cycle: the block is enabled, `phase` is one of 1 (start), 2 (repeated start), 3 (address), 4 (data) or 5 (acknowledge), `sda_intent` is 1, and synchronized SCL is high while synchronized SDA is low. The flag rises on the third rising edge after the line change. Phases 0, 6 and 7 never set it. Neither does `sda_intent` at 0, nor a low SCL.
- R8: `collision` keeps its value until `clr_collision` is high at a clock edge. A collision condition in that same cycle wins over the clear.
- R9: `sda_release` is high whenever `collision` is set, and also in any cycle where the R7 condition holds on the synchronized lines. That second case occurs one edge before the flag rises.
- R10: A change of SDA while SCL is low changes neither `start_seen` nor `stop_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Monitor enable |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_intent | input | 1 | SDA level the local master intends (1 = released) |
| phase | input | PHASE_W | Transfer phase code (0 idle, 1 start, 2 repeated start, 3 address, 4 data, 5 acknowledge) |
| irq_en | input | 1 | Interrupt enable |
| clr_collision | input | 1 | Clears the collision flag |
| start_seen | output | 1 | Start condition seen last |
| stop_seen | output | 1 | Stop condition seen last |
| bus_free | output | 1 | Bus may be taken by this master |
| collision | output | 1 | Sticky arbitration-loss flag |
| irq | output | 1 | One-cycle interrupt pulse |
| sda_release | output | 1 | Forces the local SDA driver to release |

## Verification
On every cycle the assertions check four things. The two status bits are never both set. Disabling the block clears them. Every detected Start or Stop lands in the matching bit and, when `irq_en` is high, raises the interrupt. The collision flag holds without a clear and always forces the driver release. Three things are shown only by the bench's scenarios: the exact edge on which each output changes after a line change, the full sweep of phases, intended levels and line levels that should or should not raise a collision, and the absence of any status change when SDA moves while SCL is low.

// File: rtl/i2c_mm_monitor.sv
module i2c_mm_monitor #(
  parameter int PHASE_W = 3,
  parameter int CHK_LO  = 1,
  parameter int CHK_HI  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               sda_intent,
  input  logic [PHASE_W-1:0] phase,
  input  logic               irq_en,
  input  logic               clr_collision,
  output logic               start_seen,
  output logic               stop_seen,
  output logic               bus_free,
  output logic               collision,
  output logic               irq,
  output logic               sda_release
);

  logic [2:0] scl_q, sda_q;
  logic scl_hi, start_det, stop_det, chk_phase, mismatch, coll_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  assign scl_hi    = scl_q[1] & scl_q[2];
  assign start_det = enable & scl_hi & sda_q[2] & ~sda_q[1];
  assign stop_det  = enable & scl_hi & ~sda_q[2] & sda_q[1];
  assign chk_phase = (int'(phase) >= CHK_LO) && (int'(phase) <= CHK_HI);
  assign mismatch  = enable & chk_phase & sda_intent & scl_q[1] & ~sda_q[1];
  assign coll_new  = mismatch & ~collision;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else if (start_det) begin
      start_seen <= 1'b1;
      stop_seen  <= 1'b0;
    end else if (stop_det) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collision <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (mismatch)           collision <= 1'b1;
      else if (clr_collision) collision <= 1'b0;
      irq <= irq_en & (start_det | stop_det | coll_new);
    end
  end

  assign bus_free    = stop_seen | (~start_seen & ~stop_seen);
  assign sda_release = collision | mismatch;

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));
  p_dis_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_seen && !stop_seen));
  p_start_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (start_seen && !stop_seen));
  p_stop_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (stop_seen && !start_seen));
  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && (start_det || stop_det)) |=> irq);
  p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && !clr_collision) |=> collision);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> sda_release);

endmodule

// File: tb/i2c_mm_monitor_bench.sv
module i2c_mm_monitor_bench;
  logic clk = 0, rst_n = 0, enable = 0, scl_in = 1, sda_in = 1, sda_intent = 0;
  logic [2:0] phase = 0;
  logic irq_en = 0, clr_collision = 0;
  logic start_seen, stop_seen, bus_free, collision, irq, sda_release;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_mm_monitor u_i2c_mm_monitor (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in), .sda_in(sda_in),
    .sda_intent(sda_intent), .phase(phase), .irq_en(irq_en), .clr_collision(clr_collision),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
    .collision(collision), .irq(irq), .sda_release(sda_release));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic status(input string req, input logic s, input logic p);
    chk({req, " start_seen"}, start_seen, s);
    chk({req, " stop_seen"}, stop_seen, p);
    chk({req, " bus_free (R5)"}, bus_free, p | (~s & ~p));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    // R1: reset values
    status("R1", 0, 0);
    chk("R1 collision", collision, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1; enable = 1; irq_en = 1;
    cyc(4);
    status("R1 idle", 0, 0);

    // R3: start
    sda_in = 0;
    cyc(2);
    chk("R3 not yet", start_seen, 0);
    cyc(1);
    status("R3", 1, 0);
    chk("R6 irq on start", irq, 1);
    cyc(1);
    chk("R6 irq single cycle", irq, 0);

    // R4: stop
    sda_in = 1;
    cyc(3);
    status("R4", 0, 1);
    chk("R6 irq on stop", irq, 1);
    cyc(1);
    chk("R6 irq single cycle stop", irq, 0);

    // R10: SDA toggles with SCL low
    scl_in = 0; cyc(3);
    sda_in = 0; cyc(4);
    status("R10 fall", 0, 1);
    sda_in = 1; cyc(4);
    status("R10 rise", 0, 1);
    chk("R10 no irq", irq, 0);
    scl_in = 1; cyc(4);

    // R6: no irq when disabled irq_en
    irq_en = 0;
    sda_in = 0; cyc(3);
    status("R3 second start", 1, 0);
    chk("R6 irq masked", irq, 0);
    cyc(1);
    chk("R6 irq masked later", irq, 0);
    irq_en = 1;

    // R2: disable clears and suppresses
    enable = 0; cyc(1);
    status("R2 cleared", 0, 0);
    sda_in = 1; cyc(4);
    sda_in = 0; cyc(4);
    status("R2 start ignored", 0, 0);
    chk("R2 no irq", irq, 0);
    sda_in = 1; cyc(4);
    enable = 1; cyc(2);

    // R7/R9 sweep: phase x intent x scl x sda
    irq_en = 0;
    for (int p = 0; p < 8; p++)
      for (int v = 0; v < 8; v++) begin
        logic exp;
        enable = 0;
        phase = 0; sda_intent = v[2]; scl_in = v[1]; sda_in = v[0];
        cyc(4);
        clr_collision = 1; cyc(1); clr_collision = 0;
        enable = 1;
        chk("R8 cleared before sweep", collision, 0);
        phase = 3'(p);
        exp = (p >= 1 && p <= 5) && v[2] && v[1] && !v[0];
        cyc(1);
        chk("R9 release with mismatch", sda_release, exp);
        cyc(1);
        chk("R7 collision sweep", collision, exp);
        phase = 0;
      end

    // R7 timing from a line change, R8 sticky and clear, R6 irq on collision
    enable = 0; scl_in = 1; sda_in = 1; cyc(4);
    clr_collision = 1; cyc(1); clr_collision = 0;
    enable = 1; irq_en = 1; phase = 4; sda_intent = 1;
    cyc(1);
    scl_in = 0; cyc(4);
    sda_in = 0; cyc(4);
    chk("R7 scl low no collision", collision, 0);
    scl_in = 1;
    cyc(1);
    chk("R9 release pending", sda_release, 0);
    cyc(1);
    chk("R9 release on mismatch", sda_release, 1);
    chk("R7 flag not yet", collision, 0);
    cyc(1);
    chk("R7 collision third edge", collision, 1);
    chk("R6 irq on collision", irq, 1);
    cyc(1);
    chk("R6 irq once per collision", irq, 0);
    clr_collision = 1; cyc(1); clr_collision = 0;
    chk("R8 set wins over clear", collision, 1);
    phase = 0; scl_in = 0; sda_in = 1; cyc(6);
    chk("R8 sticky", collision, 1);
    chk("R9 release held", sda_release, 1);
    clr_collision = 1; cyc(1); clr_collision = 0;
    chk("R8 cleared", collision, 0);
    chk("R9 release dropped", sda_release, 0);

    // R1: reset mid-operation
    scl_in = 1; cyc(4); sda_in = 0; cyc(4);
    status("R3 before reset", 1, 0);
    rst_n = 0; cyc(1);
    status("R1 reset again", 0, 0);
    rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule